// File: doc/BRIEF.md
# Conversion Result Queue with Host Port, DMA Request and Interrupts

The block queues signed conversion results, each 12 bits plus a sign bit in two's complement, in a 32-entry first-in first-out store. A host reads them over a register port whose data path is either 16 or 8 bits wide. In the narrow mode each result takes two reads: the low byte first, then the high byte. The upper data lane is released to high impedance in that mode.

An active-high DMA request follows the fill level of the queue with hysteresis. It rises once the entry count equals a programmed threshold. It then stays high until the queue has been drained completely.

Eight event inputs set sticky flags. Any flag whose enable bit is set pulls the active-low interrupt output. Reading the flag register returns the flags and clears them. An event that arrives in the same cycle as that read is kept as a new flag.

Host register map (`reg_sel`):

| Address | Read | Write |
|---|---|---|
| 0 | queue head | none |
| 1 | event enable mask | event enable mask |
| 2 | event flags, cleared by the read | none |
| 3 | entry count and overflow bit | DMA threshold |

Top module: `result_fifo_host`

## Requirements
- R1: After reset the queue is empty, every flag, the enable mask, the threshold and the overflow bit are zero, `irq_n` is high and `dma_req` is low.
- R2: Results come out in the order they were written, and the queue holds 32 of them. In 16-bit mode a read of address 0 returns the head result sign-extended to 16 bits and removes it.
- R3: A result written while 32 entries are held is discarded and sets the overflow bit, which is bit 6 of address 3. A read of address 3 clears that bit.
- R4: A read of address 0 while the queue is empty returns zero. It changes neither the count nor the next result that is read.
- R5: With `bus_8bit` high, the first read of address 0 returns bits 7:0 of the sign-extended result. The second read returns bits 15:8 and removes the entry. The count does not change between the two reads.
- R6: With `bus_8bit` high, `rd_data[15:8]` is zero and `hi_oe` is low. With it low, `hi_oe` is high during every read.
- R7: One cycle after the count equals a nonzero threshold, `dma_req` goes high. It stays high until the count reaches zero and falls in the following cycle.
- R8: A threshold of zero keeps `dma_req` low at any fill level.
- R9: Flags latch events whatever the mask holds. `irq_n` is low exactly when a flag and its mask bit (address 1, bit i for event i) are both set.
- R10: A read of address 2 returns the flags in bits 7:0 and clears them. An event that arrives in the cycle of that read stays pending.
- R11: Address 3 returns the entry count in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_wr | input | 1 | Result write strobe |
| res_data | input | 13 | Signed result to queue |
| evt | input | 8 | Event pulses, one per source |
| bus_8bit | input | 1 | High selects the 8-bit host path |
| reg_sel | input | 2 | Host register address |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Host read data, valid while `rd_en` is high |
| hi_oe | output | 1 | Drive enable for `rd_data[15:8]` |
| dma_req | output | 1 | DMA request, active high |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions check several invariants on every cycle:
- the count never passes 32, and a write to a full queue changes nothing but the overflow bit;
- an empty read leaves the read pointer where it was;
- the DMA request only falls after an empty cycle, and cannot rise with a zero threshold;
- events always land in the flags, and a flag read with no new event releases the interrupt.

Other behaviour needs data and sequences, so only the bench scenarios show it. That includes result ordering and sign extension, the byte order in narrow mode, the point at which the request rises for each threshold, the mask gating of each source, and the event that collides with a flag read.

// File: rtl/result_fifo_host.sv
module result_fifo_host #(
  parameter int DEPTH = 32,
  parameter int RES_W = 13,
  parameter int EVT_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_wr,
  input  logic [RES_W-1:0] res_data,
  input  logic [EVT_N-1:0] evt,
  input  logic             bus_8bit,
  input  logic [1:0]       reg_sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  output logic             hi_oe,
  output logic             dma_req,
  output logic             irq_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [RES_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, thr;
  logic [EVT_N-1:0] flags, mask;
  logic             ovf, byte_hi, dma_q;

  logic rd_fifo, rd_flags, rd_stat, empty, full, push, pop;
  logic [15:0] wide, fifo_word, mux;
  logic [RES_W-1:0] head;

  assign rd_fifo  = rd_en && reg_sel == 2'd0;
  assign rd_flags = rd_en && reg_sel == 2'd2;
  assign rd_stat  = rd_en && reg_sel == 2'd3;
  assign empty    = cnt == '0;
  assign full     = cnt == CW'(DEPTH);
  assign push     = res_wr && !full;
  assign pop      = rd_fifo && !empty && (!bus_8bit || byte_hi);

  assign head = mem[rptr];
  assign wide = {{(16-RES_W){head[RES_W-1]}}, head};

  always_comb begin
    if (empty)         fifo_word = '0;
    else if (!bus_8bit) fifo_word = wide;
    else if (byte_hi)  fifo_word = {8'h00, wide[15:8]};
    else               fifo_word = {8'h00, wide[7:0]};
  end

  always_comb begin
    case (reg_sel)
      2'd0:    mux = fifo_word;
      2'd1:    mux = 16'(mask);
      2'd2:    mux = 16'(flags);
      default: mux = 16'({ovf, cnt});
    endcase
  end

  assign rd_data = !rd_en ? '0 : bus_8bit ? {8'h00, mux[7:0]} : mux;
  assign hi_oe   = rd_en && !bus_8bit;
  assign dma_req = dma_q;
  assign irq_n   = ~|(flags & mask);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= res_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      thr     <= '0;
      mask    <= '0;
      flags   <= '0;
      ovf     <= 1'b0;
      byte_hi <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);

      if (!bus_8bit)              byte_hi <= 1'b0;
      else if (rd_fifo && !empty) byte_hi <= !byte_hi;

      ovf   <= (ovf && !rd_stat) || (res_wr && full);
      flags <= (flags & ~{EVT_N{rd_flags}}) | evt;

      if (wr_en && reg_sel == 2'd1) mask <= wr_data[EVT_N-1:0];
      if (wr_en && reg_sel == 2'd3) thr  <= wr_data[CW-1:0];

      if (empty)                       dma_q <= 1'b0;
      else if (thr != '0 && cnt == thr) dma_q <= 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && res_wr && !pop |=> cnt == CW'(DEPTH) && ovf);
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fifo && empty |=> $stable(rptr));
  p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q && !empty |=> dma_q);
  p_dma_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_q) |-> $past(empty));
  p_thr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr == '0 && !dma_q |=> !dma_q);
  p_irq_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags && evt == '0 |=> irq_n);
  p_evt_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt != '0 |=> (flags & $past(evt)) == $past(evt));
endmodule

// File: tb/result_fifo_host_bench.sv
`timescale 1ns/100ps
module result_fifo_host_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        res_wr = 1'b0, bus_8bit = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [12:0] res_data = '0;
  logic [7:0]  evt = '0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] wr_data = '0, rd_data, rv;
  logic        hi_oe, dma_req, irq_n, oe_seen;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = !clk;

  result_fifo_host u_result_fifo_host (
    .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data), .evt(evt),
    .bus_8bit(bus_8bit), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .hi_oe(hi_oe), .dma_req(dma_req),
    .irq_n(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] val(input int i);
    return 13'(i * 397 + 4100);
  endfunction

  function automatic logic [15:0] sx(input logic [12:0] v);
    return {{3{v[12]}}, v};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input logic [12:0] v);
    @(negedge clk); res_wr = 1'b1; res_data = v;
    @(negedge clk); res_wr = 1'b0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; reg_sel = a;
    #1 d = rd_data; oe_seen = hi_oe;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 irq_n", irq_n, 1);
    chk("R1 dma_req", dma_req, 0);
    hrd(2'd3, rv); chk("R1 status", rv, 0);
    hrd(2'd1, rv); chk("R1 mask", rv, 0);
    hrd(2'd2, rv); chk("R1 flags", rv, 0);

    hrd(2'd0, rv); chk("R4 empty read", rv, 0);
    hrd(2'd3, rv); chk("R4 count after empty read", rv, 0);
    put(13'h1abc);
    hrd(2'd0, rv); chk("R4 next result", rv, sx(13'h1abc));
    chk("R6 hi_oe in 16-bit", oe_seen, 1);

    for (int i = 0; i < 32; i++) put(val(i));
    hrd(2'd3, rv); chk("R11 count full", rv, 16'h0020);
    put(13'h0555);
    hrd(2'd3, rv); chk("R3 overflow set", rv, 16'h0060);
    hrd(2'd3, rv); chk("R3 overflow cleared", rv, 16'h0020);
    for (int i = 0; i < 32; i++) begin
      hrd(2'd0, rv); chk("R2 order", rv, sx(val(i)));
    end
    hrd(2'd3, rv); chk("R2 drained", rv, 0);

    bus_8bit = 1'b1;
    for (int i = 0; i < 20; i++) put(val(i + 40));
    for (int i = 0; i < 20; i++) begin
      hrd(2'd0, rv); chk("R5 low byte", rv, {8'h00, sx(val(i + 40))[7:0]});
      chk("R6 hi_oe in 8-bit", oe_seen, 0);
      if (i == 0) begin
        hrd(2'd3, rv); chk("R5 count between bytes", rv, 16'd20);
      end
      hrd(2'd0, rv); chk("R5 high byte", rv, {8'h00, sx(val(i + 40))[15:8]});
    end
    hrd(2'd3, rv); chk("R5 drained", rv, 0);
    bus_8bit = 1'b0;

    for (int t = 1; t <= 32; t += 31) begin
      hwr(2'd3, 16'(t));
      for (int k = 1; k <= t; k++) begin
        put(val(k)); tick();
        chk("R7 rise", dma_req, k >= t);
      end
      for (int k = t; k >= 1; k--) begin
        hrd(2'd0, rv); tick();
        chk("R7 hold until empty", dma_req, k > 1);
      end
    end
    hwr(2'd3, 16'd6);
    for (int k = 1; k <= 8; k++) put(val(k));
    tick(); chk("R7 rise at six", dma_req, 1);
    for (int k = 1; k <= 8; k++) hrd(2'd0, rv);
    tick(); chk("R7 fall at empty", dma_req, 0);
    hwr(2'd3, 16'd0);
    for (int k = 1; k <= 32; k++) begin
      put(val(k)); tick();
      chk("R8 threshold zero", dma_req, 0);
    end
    for (int k = 1; k <= 32; k++) hrd(2'd0, rv);

    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] mk;
        mk = (m == 0) ? 8'(1 << i) : ~8'(1 << i);
        hwr(2'd1, 16'(mk));
        pulse(8'(1 << i));
        chk("R9 irq gating", irq_n, m == 1);
        hrd(2'd2, rv); chk("R10 flags read", rv, 16'(1 << i));
        chk("R10 irq released", irq_n, 1);
      end
    end

    hwr(2'd1, 16'h00ff);
    pulse(8'h01);
    @(negedge clk); rd_en = 1'b1; reg_sel = 2'd2; evt = 8'h02;
    #1 rv = rd_data;
    @(negedge clk); rd_en = 1'b0; evt = '0;
    chk("R10 read during event", rv, 16'h0001);
    chk("R10 event kept irq", irq_n, 0);
    hrd(2'd2, rv); chk("R10 event kept flag", rv, 16'h0002);
    hwr(2'd1, 16'h0000);
    pulse(8'ha5);
    chk("R9 masked irq", irq_n, 1);
    hrd(2'd2, rv); chk("R9 flags latch masked", rv, 16'h00a5);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule